// File: doc/BRIEF.md
# Mixed-Symmetry Pre-Add FIR Filter

This block is a fully parallel FIR filter with an odd number of taps. The delay line holds the most recent samples. Tap k and its mirror tap N-1-k share one coefficient magnitude. Each such pair is set at elaboration as either even, where the two samples are summed, or odd, where the mirror sample is subtracted from the near one. Only the combined sample is multiplied, so each pair needs one multiplier. The lone centre tap has a multiplier of its own, and that multiplier is left out when its coefficient is zero. Even, odd and mixed patterns all use the same datapath, so a set such as 1, 2, 3, 4, 0, -4, 3, -2, 1 needs four multipliers rather than nine.

Samples arrive as a signed stream qualified by a valid strobe, and the filter returns one full-precision signed result for each accepted sample. The coefficients, the per-pair symmetry flags and the tap count are parameters. The active-low reset is asynchronous and is expected to be released in step with the clock.

Top module: `fir_mixsym`

## Requirements
- R1: Every accepted input sample (in_valid high at a rising edge) yields exactly one result, and out_valid is in_valid delayed by exactly 4 clock cycles.
- R2: With pair k given signed coefficient c[k], the full tap list is c[k] at tap k and, at tap N-1-k, c[k] when pair flag bit k is 0 (even) or -c[k] when it is 1 (odd). The result is the sum over taps i of coef[i]*x[n-i], where x[n] is the newest accepted sample. The default mixed set 1,2,3,4,0,-4,3,-2,1 (flags 4'b1010, centre 0) must be reproduced exactly.
- R3: The result is full precision: it never wraps, including for inputs alternating between +127 and -128 and for constant extreme inputs.
- R4: The delay line moves only on cycles with in_valid high. While in_valid is low, in_data is ignored, and the held samples are unchanged for later results.
- R5: While rst_n is low, out_valid and out_data are 0. After reset, earlier samples count as zero in the result.
- R6: A purely even set with a nonzero centre tap (1,2,3,4,5,4,3,2,1, flags 4'b0000, centre 5) is computed exactly.
- R7: A purely odd set with a zero centre tap (1,2,3,4,0,-4,-3,-2,-1, flags 4'b1111) is computed exactly.
- R8: out_data keeps its last value in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW (8) | Signed input sample |
| out_valid | output | 1 | Result strobe |
| out_data | output | SW (18) | Signed full-precision result |

## Verification
The filter is driven with a unit impulse and with a negative full-scale impulse. Their responses read back the signed tap list in order, which separates a swapped pair flag, a reversed tap order and a missing centre product. Constant and alternating full-scale inputs push the even and odd pre-adders to their largest magnitudes, which exposes width loss. A full sweep of all 256 input codes and a pseudo-random stream, both with irregular gaps carrying junk data, show that idle cycles neither shift nor disturb the delay line. A reset in mid-stream shows that stale samples are dropped. Three instances with mixed, even-plus-centre and odd-only sets take the same stream, so each variant of the pre-adder and of the centre multiplier is tried.

// File: rtl/fir_mixsym_pkg.sv
package fir_mixsym_pkg;

  // Result width needed to add NTERMS operands of width W without overflow.
  function automatic int sum_width(input int w, input int nterms);
    return w + $clog2(nterms + 1);
  endfunction

  function automatic int abs_int(input int v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
  parameter int DW    = 8,
  parameter int NTAPS = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DW-1:0]         in_data,
  output logic [NTAPS*DW-1:0]   taps,
  output logic                  tap_valid
);

  // Tap i occupies bits [i*DW +: DW] and holds x[n-i].
  logic [NTAPS*DW-1:0] taps_d, taps_q;
  logic                tv_d, tv_q;

  always_comb begin
    taps_d = taps_q;
    if (in_valid) begin
      taps_d = {taps_q[(NTAPS-1)*DW-1:0], in_data};
    end
    tv_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q <= '0;
      tv_q   <= 1'b0;
    end else begin
      taps_q <= taps_d;
      tv_q   <= tv_d;
    end
  end

  assign taps      = taps_q;
  assign tap_valid = tv_q;

endmodule

// File: rtl/fir_pair_mac.sv
module fir_pair_mac #(
  parameter int                    DW   = 8,
  parameter int                    CW   = 6,
  parameter logic signed [CW-1:0]  COEF = '0,
  parameter bit                    ODD  = 1'b0,
  localparam int                   PW   = DW + 1,
  localparam int                   MW   = PW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_pre,
  input  logic            en_mul,
  input  logic [DW-1:0]   near_s,
  input  logic [DW-1:0]   far_s,
  output logic [MW-1:0]   prod
);

  logic signed [PW-1:0] pre_d, pre_q;
  logic signed [MW-1:0] mul_d, mul_q;

  generate
    if (ODD) begin : g_sub
      always_comb pre_d = PW'($signed(near_s)) - PW'($signed(far_s));
    end else begin : g_add
      always_comb pre_d = PW'($signed(near_s)) + PW'($signed(far_s));
    end
  endgenerate

  always_comb mul_d = MW'(pre_q) * MW'(COEF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      mul_q <= '0;
    end else begin
      if (en_pre) pre_q <= pre_d;
      if (en_mul) mul_q <= mul_d;
    end
  end

  assign prod = mul_q;

endmodule

// File: rtl/fir_center_mac.sv
module fir_center_mac #(
  parameter int                    DW   = 8,
  parameter int                    CW   = 6,
  parameter logic signed [CW-1:0]  COEF = '0,
  localparam int                   MW   = DW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_pre,
  input  logic            en_mul,
  input  logic [DW-1:0]   mid_s,
  output logic [MW-1:0]   prod
);

  // The first register only delays the sample so the centre path lines up
  // with the pre-adder stage of the pairs.
  logic signed [DW-1:0] mid_q;
  logic signed [MW-1:0] mul_d, mul_q;

  always_comb mul_d = MW'(mid_q) * MW'(COEF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
      mul_q <= '0;
    end else begin
      if (en_pre) mid_q <= $signed(mid_s);
      if (en_mul) mul_q <= mul_d;
    end
  end

  assign prod = mul_q;

endmodule

// File: rtl/fir_sum_stage.sv
module fir_sum_stage #(
  parameter int NPAIR = 4,
  parameter int MW    = 15,
  parameter int CMW   = 14,
  parameter int SW    = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [NPAIR*MW-1:0]   pair_prod,
  input  logic [CMW-1:0]        ctr_prod,
  output logic [SW-1:0]         sum
);

  logic signed [SW-1:0] sum_d, sum_q;

  always_comb begin
    sum_d = SW'($signed(ctr_prod));
    for (int k = 0; k < NPAIR; k++) begin
      sum_d = sum_d + SW'($signed(pair_prod[k*MW +: MW]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (en) begin
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;

endmodule

// File: rtl/fir_mixsym.sv
module fir_mixsym
  import fir_mixsym_pkg::*;
#(
  parameter int                        DW        = 8,
  parameter int                        CW        = 6,
  parameter int                        NTAPS     = 9,
  parameter logic [((NTAPS-1)/2)*CW-1:0] PAIR_COEF = 24'({6'd4, 6'd3, 6'd2, 6'd1}),
  parameter logic [((NTAPS-1)/2)-1:0]  PAIR_ODD  = 4'b1010,
  parameter logic signed [CW-1:0]      CTR_COEF  = '0,
  localparam int                       NPAIR     = (NTAPS - 1) / 2,
  localparam int                       MW        = DW + 1 + CW,
  localparam int                       CMW       = DW + CW,
  localparam int                       SW        = sum_width(MW, NPAIR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_data
);

  logic [NTAPS*DW-1:0] taps;
  logic                v_dl;
  logic                v_pa_d, v_pa_q;
  logic                v_pr_d, v_pr_q;
  logic                v_out_d, v_out_q;
  logic [NPAIR*MW-1:0] pair_prod;
  logic [CMW-1:0]      ctr_prod;
  logic [SW-1:0]       sum;

  fir_tap_line #(.DW(DW), .NTAPS(NTAPS)) u_taps (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .taps      (taps),
    .tap_valid (v_dl)
  );

  generate
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      localparam logic signed [CW-1:0] PC = PAIR_COEF[k*CW +: CW];
      fir_pair_mac #(.DW(DW), .CW(CW), .COEF(PC), .ODD(PAIR_ODD[k])) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_pre (v_dl),
        .en_mul (v_pa_q),
        .near_s (taps[k*DW +: DW]),
        .far_s  (taps[(NTAPS-1-k)*DW +: DW]),
        .prod   (pair_prod[k*MW +: MW])
      );
    end

    if (CTR_COEF != '0) begin : g_ctr
      fir_center_mac #(.DW(DW), .CW(CW), .COEF(CTR_COEF)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_pre (v_dl),
        .en_mul (v_pa_q),
        .mid_s  (taps[NPAIR*DW +: DW]),
        .prod   (ctr_prod)
      );
    end else begin : g_no_ctr
      logic unused_mid;
      assign unused_mid = ^taps[NPAIR*DW +: DW];
      assign ctr_prod   = '0;
    end
  endgenerate

  fir_sum_stage #(.NPAIR(NPAIR), .MW(MW), .CMW(CMW), .SW(SW)) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (v_pr_q),
    .pair_prod (pair_prod),
    .ctr_prod  (ctr_prod),
    .sum       (sum)
  );

  always_comb begin
    v_pa_d  = v_dl;
    v_pr_d  = v_pa_q;
    v_out_d = v_pr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_pa_q  <= 1'b0;
      v_pr_q  <= 1'b0;
      v_out_q <= 1'b0;
    end else begin
      v_pa_q  <= v_pa_d;
      v_pr_q  <= v_pr_d;
      v_out_q <= v_out_d;
    end
  end

  assign out_valid = v_out_q;
  assign out_data  = $signed(sum);

endmodule

// File: rtl/fir_mixsym_chk.sv
module fir_mixsym_chk
  import fir_mixsym_pkg::*;
#(
  parameter int                          DW        = 8,
  parameter int                          CW        = 6,
  parameter int                          NTAPS     = 9,
  parameter int                          SW        = 18,
  parameter logic [((NTAPS-1)/2)*CW-1:0] PAIR_COEF = '0,
  parameter logic signed [CW-1:0]        CTR_COEF  = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [DW-1:0]        newest,
  input logic                 out_valid,
  input logic signed [SW-1:0] out_data
);

  localparam int NPAIR = (NTAPS - 1) / 2;

  function automatic int calc_bound();
    int b;
    b = abs_int(int'(CTR_COEF)) * (2 ** (DW - 1));
    for (int k = 0; k < NPAIR; k++) begin
      b = b + abs_int(int'($signed(PAIR_COEF[k*CW +: CW]))) * (2 ** DW);
    end
    return b;
  endfunction

  localparam int BOUND = calc_bound();

  logic [3:0] vhist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vhist <= '0;
    else        vhist <= {vhist[2:0], in_valid};
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vhist[3]);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_data) <= BOUND && int'(out_data) >= -BOUND));

  assert_tap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(newest));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind fir_mixsym fir_mixsym_chk #(
  .DW(DW), .CW(CW), .NTAPS(NTAPS), .SW(SW),
  .PAIR_COEF(PAIR_COEF), .CTR_COEF(CTR_COEF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .newest    (taps[DW-1:0]),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/fir_mixsym_test.sv
module fir_mixsym_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int CW    = 6;
  localparam int NTAPS = 9;
  localparam int SW    = DW + 1 + CW + 3;
  localparam int LAT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid_m, out_valid_e, out_valid_o;
  logic signed [SW-1:0] out_m, out_e, out_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  // mixed set (R2), even with centre (R6), odd only (R7)
  fir_mixsym #(.PAIR_COEF(24'({6'd4, 6'd3, 6'd2, 6'd1})), .PAIR_ODD(4'b1010),
               .CTR_COEF(6'sd0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_m), .out_data(out_m));
  fir_mixsym #(.PAIR_COEF(24'({6'd4, 6'd3, 6'd2, 6'd1})), .PAIR_ODD(4'b0000),
               .CTR_COEF(6'sd5)) uut_even (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_e), .out_data(out_e));
  fir_mixsym #(.PAIR_COEF(24'({6'd4, 6'd3, 6'd2, 6'd1})), .PAIR_ODD(4'b1111),
               .CTR_COEF(6'sd0)) uut_odd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid_o), .out_data(out_o));

  int cm [NTAPS] = '{1, 2, 3, 4, 0, -4, 3, -2, 1};
  int ce [NTAPS] = '{1, 2, 3, 4, 5, 4, 3, 2, 1};
  int co [NTAPS] = '{1, 2, 3, 4, 0, -4, -3, -2, -1};
  int hist [NTAPS];

  int q_m[$], q_e[$], q_o[$], q_cyc[$];
  string q_tag[$];
  string phase = "R2";
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_sent = 0;
  int n_got = 0;
  logic signed [SW-1:0] last_m = '0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic send(input bit v, input int d);
    int sm, se, so;
    @(negedge clk);
    in_valid = v;
    in_data  = DW'(d);
    if (v) begin
      for (int i = NTAPS - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = int'($signed(DW'(d)));
      sm = 0; se = 0; so = 0;
      for (int i = 0; i < NTAPS; i++) begin
        sm += cm[i] * hist[i];
        se += ce[i] * hist[i];
        so += co[i] * hist[i];
      end
      q_m.push_back(sm); q_e.push_back(se); q_o.push_back(so);
      q_cyc.push_back(cyc); q_tag.push_back(phase);
      n_sent++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 8'h5A ^ i);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    q_m.delete(); q_e.delete(); q_o.delete(); q_cyc.delete(); q_tag.delete();
    for (int i = 0; i < NTAPS; i++) hist[i] = 0;
    n_sent = 0; n_got = 0;
    last_m = '0;
    @(negedge clk);
    check("R5 reset out_valid", int'(out_valid_m | out_valid_e | out_valid_o), 0);
    check("R5 reset out_data mixed", int'(out_m), 0);
    check("R5 reset out_data even", int'(out_e), 0);
    check("R5 reset out_data odd", int'(out_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid_m) begin
        if (q_m.size() == 0) begin
          check("R1 unexpected output", 1, 0);
        end else begin
          check({q_tag[0], " mixed"}, int'(out_m), q_m[0]);
          check("R1 latency", cyc - q_cyc[0], LAT);
          void'(q_m.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
          n_got++;
        end
        last_m = out_m;
      end else begin
        check("R8 hold", int'(out_m), int'(last_m));
      end
      if (out_valid_e) begin
        if (q_e.size() == 0) check("R6 unexpected output", 1, 0);
        else begin check("R6 even+centre", int'(out_e), q_e[0]); void'(q_e.pop_front()); end
      end
      if (out_valid_o) begin
        if (q_o.size() == 0) check("R7 unexpected output", 1, 0);
        else begin check("R7 odd only", int'(out_o), q_o[0]); void'(q_o.pop_front()); end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NTAPS; i++) hist[i] = 0;
    do_reset();

    // R5: first result after reset sees zeros for earlier samples
    phase = "R5";
    send(1'b1, 7);
    idle(8);

    // R2: impulse reads out the signed tap list in order
    phase = "R2";
    send(1'b1, 1);
    for (int i = 0; i < NTAPS + 1; i++) send(1'b1, 0);
    send(1'b1, -128);
    for (int i = 0; i < NTAPS + 1; i++) send(1'b1, 0);

    // R3: extreme constant and alternating inputs
    phase = "R3";
    for (int i = 0; i < 12; i++) send(1'b1, 127);
    for (int i = 0; i < 12; i++) send(1'b1, -128);
    for (int i = 0; i < 16; i++) send(1'b1, (i % 2) ? -128 : 127);

    // R4: full code sweep with gaps carrying junk data
    phase = "R4";
    for (int v = -128; v < 128; v++) begin
      send(1'b1, v);
      if ((v & 3) == 1) send(1'b0, 8'hA5);
      if ((v & 7) == 3) idle(3);
    end

    // R4: pseudo-random data with pseudo-random valid gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[0] | lfsr[3], int'($signed(lfsr[15:8])));
    end
    idle(8);
    check("R1 outputs match inputs", n_got, n_sent);

    // R5: reset in mid-stream discards held samples
    phase = "R5";
    for (int i = 0; i < 5; i++) send(1'b1, 100 - 30 * i);
    do_reset();
    send(1'b1, 1);
    for (int i = 0; i < NTAPS; i++) send(1'b1, 0);
    idle(8);
    check("R1 outputs match inputs after reset", n_got, n_sent);
    check("R6 queue drained", q_e.size(), 0);
    check("R7 queue drained", q_o.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule